// File: doc/BRIEF.md
# Sample-Level Gain Control Loop Driver

This block watches a stream of 10-bit converter samples and decides, once per averaging window, whether the received signal is too strong or too weak. Each accepted sample is first brought to two's complement (a configuration pin says whether it arrives as offset binary or already signed). Its absolute value is taken as that sample's level. The levels are summed over a window of 64 or 256 accepted samples. The sum is then shifted down to an average and compared against a signed 4-bit threshold scaled onto the 9-bit magnitude range.

The comparison result is held in a one-bit pump state. That state drives a single output pin that charges or discharges an external integrator, and the integrator in turn sets the front-end gain. A polarity pin inverts the output so it suits integrators of either sense. A synchronous clear input returns the loop to its starting point without a full reset.

Samples enter on a valid/ready handshake. The block holds `smp_ready` high in every cycle except those in which `loop_clear` is high. A sample counts only in a cycle where both `smp_valid` and `smp_ready` are high. A source that sees ready low must hold its sample and try again.

Top module: `agc_level_ctrl`

## Requirements
- R1: With `fmt_signed`=0 a sample is offset binary: code 512 is zero, so the level is |code − 512|. With `fmt_signed`=1 the sample is ten-bit two's complement.
- R2: A sample's level is its absolute value, and the most negative input (−512) has level 512.
- R3: The window is 64 accepted samples when `win_long`=0 and 256 when `win_long`=1. The average is the window sum shifted right by 6 or 8, with truncation.
- R4: At the end of a window the pump state becomes 1 exactly when the average is strictly greater than signed(`thr_level`) × 32, and 0 otherwise.
- R5: The pump state changes only at the clock edge that accepts the last sample of a window, and holds its value at every other time.
- R6: `pump_out` equals the pump state XOR `pump_invert`. With `pump_invert`=0, a 1 on `pump_out` means the average is above threshold.
- R7: While `loop_clear` is high, `smp_ready` is low, and the clock edge clears the running sum, the sample count and the pump state. The next window then starts with the first sample accepted afterwards.
- R8: A low `rst_n` clears the same state at once, without waiting for a clock edge.
- R9: A cycle with `smp_valid` low adds nothing to the sum or the count, whatever value is on `smp_data`.
- R10: If `win_long` is changed partway through a window, the window ends at the first accepted sample whose count reaches at least the newly selected length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data | input | 10 | Converter sample |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Sample accepted this cycle if valid |
| fmt_signed | input | 1 | 1: two's complement input, 0: offset binary |
| win_long | input | 1 | 1: 256-sample window, 0: 64-sample window |
| thr_level | input | 4 | Signed threshold, in units of 32 on the level scale |
| pump_invert | input | 1 | Inverts the output sense |
| loop_clear | input | 1 | Synchronous clear of the loop state |
| pump_out | output | 1 | Charge/discharge drive to the integrator |

## Verification
A new pump decision is due at the same rising edge that accepts the last sample of a window. No register stands between that edge and the output pin. The bench drives each sample at a falling edge and checks `pump_out` at the next falling edge after the final sample. It also checks one cycle earlier, after the second-to-last sample, to confirm the old value is still held. A change of polarity reaches the output with no clock, so it is checked a moment after the pin changes. A clear takes effect at the following rising edge and is checked at the falling edge after that.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } smp_fmt_e;
endpackage

// File: rtl/agc_level.sv
module agc_level #(
  parameter int SMP_W = 10
) (
  input  logic [SMP_W-1:0] code,
  input  logic             fmt_signed,
  output logic [SMP_W-1:0] mag
);
  import agc_pkg::*;
  logic [SMP_W-1:0] twos;

  always_comb begin
    if (smp_fmt_e'(fmt_signed) == FMT_TWOS) twos = code;
    else twos = {~code[SMP_W-1], code[SMP_W-2:0]};
    // most negative value maps onto itself, read as unsigned full scale
    mag = twos[SMP_W-1] ? (~twos + 1'b1) : twos;
  end
endmodule

// File: rtl/agc_accum.sv
module agc_accum #(
  parameter int SMP_W    = 10,
  parameter int SHORT_LG = 6,
  parameter int LONG_LG  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             win_long,
  input  logic [SMP_W-1:0] mag,
  output logic             win_end,
  output logic [SMP_W-1:0] avg
);
  localparam int ACC_W = SMP_W + LONG_LG;
  localparam int CNT_W = LONG_LG;
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'((1 << SHORT_LG) - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'((1 << LONG_LG) - 1);

  logic [ACC_W-1:0] acc_q, sum_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    last_idx = win_long ? LAST_LONG : LAST_SHORT;
    sum_nx   = acc_q + ACC_W'(mag);
    win_end  = take && (cnt_q >= last_idx);
    avg      = win_long ? SMP_W'(sum_nx >> LONG_LG) : SMP_W'(sum_nx >> SHORT_LG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear || win_end) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      acc_q <= sum_nx;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/agc_decide.sv
module agc_decide #(
  parameter int SMP_W = 10,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             win_end,
  input  logic [SMP_W-1:0] avg,
  input  logic [THR_W-1:0] thr_level,
  input  logic             pump_invert,
  output logic             pump_out
);
  localparam int SCALE_SH = SMP_W - 1 - THR_W;
  localparam int EXT_W    = SMP_W + 1 - THR_W - SCALE_SH;

  logic signed [SMP_W:0] thr_scaled;
  logic signed [SMP_W:0] avg_s;
  logic                  above;
  logic                  pump_q;

  always_comb begin
    thr_scaled = {{EXT_W{thr_level[THR_W-1]}}, thr_level, {SCALE_SH{1'b0}}};
    avg_s      = {1'b0, avg};
    above      = avg_s > thr_scaled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pump_q <= 1'b0;
    else if (clear)   pump_q <= 1'b0;
    else if (win_end) pump_q <= above;
  end

  assign pump_out = pump_q ^ pump_invert;
endmodule

// File: rtl/agc_level_ctrl.sv
module agc_level_ctrl #(
  parameter int SMP_W    = 10,
  parameter int THR_W    = 4,
  parameter int SHORT_LG = 6,
  parameter int LONG_LG  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic             fmt_signed,
  input  logic             win_long,
  input  logic [THR_W-1:0] thr_level,
  input  logic             pump_invert,
  input  logic             loop_clear,
  output logic             pump_out
);
  logic             take;
  logic [SMP_W-1:0] mag;
  logic [SMP_W-1:0] avg;
  logic             win_end;

  assign smp_ready = ~loop_clear;
  assign take      = smp_valid & smp_ready;

  agc_level #(.SMP_W(SMP_W)) u_level (
    .code       (smp_data),
    .fmt_signed (fmt_signed),
    .mag        (mag)
  );

  agc_accum #(.SMP_W(SMP_W), .SHORT_LG(SHORT_LG), .LONG_LG(LONG_LG)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (loop_clear),
    .take     (take),
    .win_long (win_long),
    .mag      (mag),
    .win_end  (win_end),
    .avg      (avg)
  );

  agc_decide #(.SMP_W(SMP_W), .THR_W(THR_W)) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (loop_clear),
    .win_end     (win_end),
    .avg         (avg),
    .thr_level   (thr_level),
    .pump_invert (pump_invert),
    .pump_out    (pump_out)
  );
endmodule

// File: rtl/agc_level_ctrl_chk.sv
module agc_level_ctrl_chk #(
  parameter int SHORT_LG = 6,
  parameter int LONG_LG  = 8
) (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic smp_ready,
  input logic win_long,
  input logic pump_invert,
  input logic loop_clear,
  input logic pump_out
);
  logic               take;
  logic               state;
  logic [LONG_LG-1:0] seen;
  logic               mixed;
  logic               long_prev;
  logic               not_last;

  assign take  = smp_valid && smp_ready;
  assign state = pump_out ^ pump_invert;
  assign not_last = win_long ? (seen != {LONG_LG{1'b1}})
                             : (seen[SHORT_LG-1:0] != {SHORT_LG{1'b1}});

  always_ff @(posedge clk) long_prev <= win_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= '0;
      mixed <= 1'b0;
    end else if (loop_clear) begin
      seen  <= '0;
      mixed <= 1'b0;
    end else begin
      if (take) seen <= seen + 1'b1;
      if (win_long != long_prev) mixed <= 1'b1;
    end
  end

  // R7: a clear leaves the pump state at zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_clear |=> (state == 1'b0));

  // R5, R9: without an accepted sample the pump state holds
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !loop_clear) |=> $stable(state));

  // R3, R5: an accepted sample short of a window boundary leaves the state alone
  p_window_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !loop_clear && !mixed && (win_long == long_prev) && not_last)
      |=> $stable(state));

  // R6: a polarity flip alone flips the output
  p_polarity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !loop_clear && $changed(pump_invert)) |-> (pump_out != $past(pump_out)));
endmodule

bind agc_level_ctrl agc_level_ctrl_chk #(.SHORT_LG(SHORT_LG), .LONG_LG(LONG_LG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .win_long    (win_long),
  .pump_invert (pump_invert),
  .loop_clear  (loop_clear),
  .pump_out    (pump_out)
);

// File: tb/sim_agc_level_ctrl.sv
`timescale 1ns/1ps
module sim_agc_level_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] smp_data = '0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic       fmt_signed = 1'b0;
  logic       win_long = 1'b0;
  logic [3:0] thr_level = '0;
  logic       pump_invert = 1'b0;
  logic       loop_clear = 1'b0;
  logic       pump_out;

  int total = 0;
  int bad = 0;
  bit st = 1'b0;

  always #2.5 clk = ~clk;

  agc_level_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .fmt_signed(fmt_signed), .win_long(win_long),
    .thr_level(thr_level), .pump_invert(pump_invert), .loop_clear(loop_clear),
    .pump_out(pump_out)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int lvl_of(logic [9:0] c, bit t);
    int v;
    v = t ? int'($signed(c)) : int'(c) - 512;
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic [9:0] code_for(int m, bit t);
    return t ? 10'(-m) : 10'(512 - m);
  endfunction

  function automatic logic [9:0] gen(int kind, int p, int i, bit t);
    case (kind)
      0: return code_for(p, t);
      1: return 10'(i * 37 + p);
      default: return t ? 10'(i % 61) : 10'(512 + i % 61);
    endcase
  endfunction

  task automatic push(logic [9:0] c);
    smp_data = c;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // one full window; expected state from the requirements
  task automatic window(string req, int kind, int p, int gaps);
    int n, sum, avg;
    logic [9:0] c;
    n = win_long ? 256 : 64;
    sum = 0;
    for (int i = 0; i < n; i++) begin
      c = gen(kind, p, i, fmt_signed);
      sum += lvl_of(c, fmt_signed);
      push(c);
      if (gaps != 0 && i < n - 1) begin
        smp_data = 10'h000;   // R9: invalid data of full-scale level
        @(negedge clk);
        smp_data = 10'h200;
        @(negedge clk);
      end
      if (i == n - 2) chk({req, " R5 hold"}, pump_out, st ^ pump_invert);
    end
    avg = sum >> (win_long ? 8 : 6);
    st = (avg > $signed(thr_level) * 32);
    chk(req, pump_out, st ^ pump_invert);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int m1;
    repeat (4) @(negedge clk);
    chk("R8 reset out", pump_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ready idle", smp_ready, 1'b1);

    // R1 R2 R4: sweep format x threshold x level with the short window
    for (int t = 0; t < 2; t++) begin
      fmt_signed = t[0];
      for (int k = -8; k < 8; k++) begin
        thr_level = 4'(k);
        m1 = (k < 0) ? 5 : k * 32;
        window("R4 zero level", 0, 0, 0);
        window("R4 at threshold", 0, m1, 0);
        window("R4 above threshold", 0, m1 + 1, 0);
        window("R1 near full", 0, 511, 0);
        window("R2 most negative", 0, 512, 0);
      end
    end

    // R3: long window, small levels (wrong shift would cross threshold)
    fmt_signed = 1'b1;
    win_long = 1'b1;
    thr_level = 4'd1;
    window("R3 long small", 2, 0, 0);
    thr_level = 4'd0;
    window("R3 long small thr0", 2, 0, 0);
    fmt_signed = 1'b0;
    for (int k = -2; k < 8; k += 3) begin
      thr_level = 4'(k);
      window("R3 long ramp", 1, k + 20, 0);
    end
    win_long = 1'b0;
    thr_level = 4'd7;
    window("R3 short ramp", 1, 5, 0);

    // R6: polarity, combinational
    thr_level = 4'd0;
    window("R6 set state", 0, 400, 0);
    pump_invert = 1'b1;
    #1 chk("R6 inverted", pump_out, ~st);
    window("R6 inverted window", 0, 0, 0);
    window("R6 inverted high", 0, 300, 0);
    @(negedge clk);
    pump_invert = 1'b0;
    #1 chk("R6 plain", pump_out, st);
    @(negedge clk);

    // R9: idle cycles with loud data between valid quiet samples
    window("R9 gaps", 0, 0, 1);
    window("R9 set high", 0, 300, 0);

    // R7: clear mid-window
    for (int i = 0; i < 10; i++) push(code_for(512, 1'b0));
    loop_clear = 1'b1;
    #1 chk("R7 ready low", smp_ready, 1'b0);
    @(negedge clk);
    loop_clear = 1'b0;
    st = 1'b0;
    chk("R7 cleared", pump_out, 1'b0);
    window("R7 sum cleared", 0, 0, 0);
    for (int i = 0; i < 10; i++) push(code_for(300, 1'b0));
    loop_clear = 1'b1;
    @(negedge clk);
    loop_clear = 1'b0;
    thr_level = 4'hF;
    for (int i = 0; i < 63; i++) push(code_for(0, 1'b0));
    chk("R7 count cleared", pump_out, 1'b0);
    push(code_for(0, 1'b0));
    chk("R7 window after clear", pump_out, 1'b1);
    st = 1'b1;

    // R10: long to short partway through
    thr_level = 4'd0;
    window("R10 prep", 0, 0, 0);
    win_long = 1'b1;
    for (int i = 0; i < 100; i++) push(code_for(400, 1'b0));
    chk("R10 hold long", pump_out, 1'b0);
    win_long = 1'b0;
    push(code_for(400, 1'b0));
    chk("R10 end on switch", pump_out, 1'b1);
    st = 1'b1;
    window("R10 next short", 0, 0, 0);

    // R8: asynchronous reset
    window("R8 prep", 0, 300, 0);
    #1 rst_n = 1'b0;
    #1 chk("R8 async", pump_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    st = 1'b0;
    window("R8 after reset", 0, 300, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule